// File: doc/BRIEF.md
# Sixteen-Bit ALU With Status Flags

This block is the integer arithmetic and logic stage of a small processor core. On each cycle where an operation is presented, it takes two 16-bit operands, a 3-bit operation code and a byte/word select. At the next clock edge it registers the result and a new set of status flags. It supports addition, addition with the stored carry, subtraction, subtraction with the stored borrow, and the bitwise AND, OR and XOR.

The flag register has 16 bits, nine of which are live. Six are status flags produced by the datapath: carry, parity, auxiliary (nibble) carry, zero, sign and signed overflow. Three are control flags: trap, interrupt enable and direction. The control flags change only through their own set and clear strobes, so arithmetic never disturbs them. The interrupt-enable flag also comes out on its own pin, where the interrupt logic can use it to gate maskable requests. The direction flag is read by string-index stepping logic elsewhere in the core.

In byte mode, only the low eight bits of each operand take part. The result's upper byte reads zero, and the width-dependent flags are taken at bit 7.

Top module: `alu16_flags`

## Requirements
- R1: While reset (`rstN` low) is asserted, and after it is released, `result` reads 16'h0000 and `flagWord` reads 16'h0002 until the first update.
- R2: With `opValid` high, opCode 0 (add) and opCode 1 (add with carry) register A+B, or A+B+CF for opCode 1. CF becomes the carry out of the top bit of the active width.
- R3: With `opValid` high, opCode 2 (subtract) and opCode 3 (subtract with borrow) register A−B, or A−B−CF for opCode 3. CF becomes 1 when a borrow out of the top bit occurred.
- R4: With `opValid` high, opCodes 4, 5 and 6 register A AND B, A OR B and A XOR B. CF, OF and AF (bits 0, 11 and 4) are cleared.
- R5: After any operation, ZF (bit 6) is 1 exactly when the active-width result is zero, and SF (bit 7) copies the result's top bit. When `byteMode` is 1, the active width is bits 7:0 and `result[15:8]` reads zero; when it is 0, the width is bits 15:0.
- R6: After any operation, PF (bit 2) is 1 when `result[7:0]` holds an even number of ones.
- R7: After an arithmetic operation, AF (bit 4) is 1 when a carry (add) or borrow (subtract) passed from bit 3 into bit 4.
- R8: After an arithmetic operation, OF (bit 11) is 1 when the signed result at the active width is out of range.
- R9: The trap (bit 8), interrupt-enable (bit 9) and direction (bit 10) flags change only through their own set/clear strobes. If the set and clear strobes are high in the same cycle, the flag is cleared. No operation alters these flags. `intEnable` mirrors bit 9.
- R10: Bit 1 of `flagWord` always reads 1. Bits 3, 5 and 15:12 always read 0.
- R11: OpCode 7, or `opValid` low, leaves `result` and all status flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Apply the operation this cycle |
| opCode | input | 3 | Operation select (0 add, 1 adc, 2 sub, 3 sbb, 4 and, 5 or, 6 xor, 7 none) |
| byteMode | input | 1 | 1 = 8-bit operation on the low bytes |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| setTrap | input | 1 | Set the trap flag |
| clrTrap | input | 1 | Clear the trap flag |
| setIntEn | input | 1 | Set the interrupt-enable flag |
| clrIntEn | input | 1 | Clear the interrupt-enable flag |
| setDir | input | 1 | Set the direction flag |
| clrDir | input | 1 | Clear the direction flag |
| result | output | 16 | Registered result |
| flagWord | output | 16 | Registered flag register |
| intEnable | output | 1 | Current interrupt-enable flag |

## Verification
The properties assume that every input carries a defined 0 or 1 at each rising edge. They also assume that `byteMode` and `opCode` describe the operation being applied whenever `opValid` is high, because the flag checks look back one cycle at those inputs. The stimulus changes every input on the falling edge only and always drives them to known values. After each applied operation it drops `opValid`, so each table row is judged on the cycle that follows it. Carry-dependent rows are ordered so that the stored CF each one consumes is known from the row before it.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_NONE = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logicSel_e;

  typedef struct packed {
    logic      wrStatus;
    logic      isSub;
    logic      useCarry;
    logic      isLogic;
    logicSel_e logicSel;
    logic      tfWr;
    logic      tfVal;
    logic      ifWr;
    logic      ifVal;
    logic      dfWr;
    logic      dfVal;
  } aluCtrl_t;

  localparam int FLAG_W = 16;
  localparam int BIT_CF = 0;
  localparam int BIT_ONE = 1;
  localparam int BIT_PF = 2;
  localparam int BIT_AF = 4;
  localparam int BIT_ZF = 6;
  localparam int BIT_SF = 7;
  localparam int BIT_TF = 8;
  localparam int BIT_IF = 9;
  localparam int BIT_DF = 10;
  localparam int BIT_OF = 11;

endpackage

// File: rtl/alu16_ctrl.sv
module alu16_ctrl
  import alu16_pkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opCode,
  input  logic       setTrap,
  input  logic       clrTrap,
  input  logic       setIntEn,
  input  logic       clrIntEn,
  input  logic       setDir,
  input  logic       clrDir,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.logicSel = LG_AND;
    if (opValid) begin
      unique case (aluOp_e'(opCode))
        OP_ADD:  ctrl.wrStatus = 1'b1;
        OP_ADC:  begin ctrl.wrStatus = 1'b1; ctrl.useCarry = 1'b1; end
        OP_SUB:  begin ctrl.wrStatus = 1'b1; ctrl.isSub = 1'b1; end
        OP_SBB:  begin ctrl.wrStatus = 1'b1; ctrl.isSub = 1'b1; ctrl.useCarry = 1'b1; end
        OP_AND:  begin ctrl.wrStatus = 1'b1; ctrl.isLogic = 1'b1; ctrl.logicSel = LG_AND; end
        OP_OR:   begin ctrl.wrStatus = 1'b1; ctrl.isLogic = 1'b1; ctrl.logicSel = LG_OR; end
        OP_XOR:  begin ctrl.wrStatus = 1'b1; ctrl.isLogic = 1'b1; ctrl.logicSel = LG_XOR; end
        default: ctrl.wrStatus = 1'b0;
      endcase
    end
    // clear strobe has priority over set strobe
    ctrl.tfWr  = setTrap | clrTrap;
    ctrl.tfVal = ~clrTrap;
    ctrl.ifWr  = setIntEn | clrIntEn;
    ctrl.ifVal = ~clrIntEn;
    ctrl.dfWr  = setDir | clrDir;
    ctrl.dfVal = ~clrDir;
  end

endmodule

// File: rtl/alu16_dpath.sv
module alu16_dpath
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtrl_t          ctrl,
  input  logic              byteMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagWord,
  output logic              intEnable
);

  localparam int BYTE_W = 8;
  localparam int MSB    = DATA_W - 1;
  localparam int BMSB   = BYTE_W - 1;

  logic [DATA_W-1:0] resReg;
  logic cfReg, pfReg, afReg, zfReg, sfReg, ofReg;
  logic tfReg, ifReg, dfReg;

  logic              carryIn;
  logic [DATA_W-1:0] bEff;
  logic [DATA_W:0]   wideSum;
  logic [BYTE_W:0]   byteSum;
  logic [DATA_W-1:0] arithRes, logicRes, nextRes;
  logic              carryOut, signA, signB, signR;
  logic              nCf, nAf, nOf, nZf, nPf;

  always_comb begin
    carryIn  = ctrl.isSub ? ~(ctrl.useCarry & cfReg) : (ctrl.useCarry & cfReg);
    bEff     = ctrl.isSub ? ~opB : opB;
    wideSum  = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, carryIn};
    byteSum  = {1'b0, opA[BMSB:0]} + {1'b0, bEff[BMSB:0]} + {{BYTE_W{1'b0}}, carryIn};

    if (byteMode) begin
      arithRes = {{(DATA_W-BYTE_W){1'b0}}, byteSum[BMSB:0]};
      carryOut = byteSum[BYTE_W];
      signA    = opA[BMSB];
      signB    = bEff[BMSB];
    end else begin
      arithRes = wideSum[MSB:0];
      carryOut = wideSum[DATA_W];
      signA    = opA[MSB];
      signB    = bEff[MSB];
    end

    unique case (ctrl.logicSel)
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      default: logicRes = opA & opB;
    endcase
    if (byteMode) logicRes[MSB:BYTE_W] = '0;

    nextRes = ctrl.isLogic ? logicRes : arithRes;
    signR   = byteMode ? nextRes[BMSB] : nextRes[MSB];
    nZf     = byteMode ? (nextRes[BMSB:0] == '0) : (nextRes == '0);
    nPf     = ~^nextRes[BMSB:0];

    if (ctrl.isLogic) begin
      nCf = 1'b0;
      nAf = 1'b0;
      nOf = 1'b0;
    end else begin
      // a carry out of the top bit means no borrow when subtracting
      nCf = ctrl.isSub ? ~carryOut : carryOut;
      nAf = opA[4] ^ opB[4] ^ nextRes[4];
      nOf = (signA == signB) && (signR != signA);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resReg <= '0;
      cfReg  <= 1'b0;
      pfReg  <= 1'b0;
      afReg  <= 1'b0;
      zfReg  <= 1'b0;
      sfReg  <= 1'b0;
      ofReg  <= 1'b0;
    end else if (ctrl.wrStatus) begin
      resReg <= nextRes;
      cfReg  <= nCf;
      pfReg  <= nPf;
      afReg  <= nAf;
      zfReg  <= nZf;
      sfReg  <= signR;
      ofReg  <= nOf;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tfReg <= 1'b0;
      ifReg <= 1'b0;
      dfReg <= 1'b0;
    end else begin
      if (ctrl.tfWr) tfReg <= ctrl.tfVal;
      if (ctrl.ifWr) ifReg <= ctrl.ifVal;
      if (ctrl.dfWr) dfReg <= ctrl.dfVal;
    end
  end

  always_comb begin
    flagWord          = '0;
    flagWord[BIT_ONE] = 1'b1;
    flagWord[BIT_CF]  = cfReg;
    flagWord[BIT_PF]  = pfReg;
    flagWord[BIT_AF]  = afReg;
    flagWord[BIT_ZF]  = zfReg;
    flagWord[BIT_SF]  = sfReg;
    flagWord[BIT_TF]  = tfReg;
    flagWord[BIT_IF]  = ifReg;
    flagWord[BIT_DF]  = dfReg;
    flagWord[BIT_OF]  = ofReg;
  end

  assign result    = resReg;
  assign intEnable = ifReg;

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic              byteMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              setTrap,
  input  logic              clrTrap,
  input  logic              setIntEn,
  input  logic              clrIntEn,
  input  logic              setDir,
  input  logic              clrDir,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagWord,
  output logic              intEnable
);

  aluCtrl_t ctrl;

  alu16_ctrl uCtrl (
    .opValid  (opValid),
    .opCode   (opCode),
    .setTrap  (setTrap),
    .clrTrap  (clrTrap),
    .setIntEn (setIntEn),
    .clrIntEn (clrIntEn),
    .setDir   (setDir),
    .clrDir   (clrDir),
    .ctrl     (ctrl)
  );

  alu16_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .byteMode  (byteMode),
    .opA       (opA),
    .opB       (opB),
    .result    (result),
    .flagWord  (flagWord),
    .intEnable (intEnable)
  );

endmodule

// File: rtl/alu16_chk.sv
module alu16_chk
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        opCode,
  input logic              byteMode,
  input logic              setTrap,
  input logic              clrTrap,
  input logic              setIntEn,
  input logic              clrIntEn,
  input logic              setDir,
  input logic              clrDir,
  input logic [DATA_W-1:0] result,
  input logic [FLAG_W-1:0] flagWord
);

  logic realOp, logicOp;
  assign realOp  = opValid && (opCode != 3'd7);
  assign logicOp = opValid && (opCode >= 3'd4) && (opCode <= 3'd6);

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(setTrap | clrTrap | setIntEn | clrIntEn | setDir | clrDir) |=> $stable(flagWord[BIT_DF:BIT_TF])); // R9

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clrIntEn |=> !flagWord[BIT_IF]); // R9

  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    logicOp |=> (!flagWord[BIT_CF] && !flagWord[BIT_OF] && !flagWord[BIT_AF])); // R4

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    realOp |=> (flagWord[BIT_ZF] == (result == '0))); // R5

  AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    realOp |=> (flagWord[BIT_SF] == ($past(byteMode) ? result[7] : result[DATA_W-1]))); // R5

  AST_BYTE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (realOp && byteMode) |=> (result[DATA_W-1:8] == '0)); // R5

  AST_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    realOp |=> (flagWord[BIT_PF] == ~^result[7:0])); // R6

  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    !realOp |=> ($stable(result) && $stable(flagWord[BIT_OF]) && $stable(flagWord[BIT_SF:BIT_CF]))); // R11

endmodule

bind alu16_flags alu16_chk #(.DATA_W(DATA_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .opCode   (opCode),
  .byteMode (byteMode),
  .setTrap  (setTrap),
  .clrTrap  (clrTrap),
  .setIntEn (setIntEn),
  .clrIntEn (clrIntEn),
  .setDir   (setDir),
  .clrDir   (clrDir),
  .result   (result),
  .flagWord (flagWord)
);

// File: tb/tb_alu16_flags.sv
module tb_alu16_flags;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [2:0] opCode = 3'd0;
  logic byteMode = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic setTrap = 0, clrTrap = 0, setIntEn = 0, clrIntEn = 0, setDir = 0, clrDir = 0;
  logic [15:0] result, flagWord;
  logic intEnable;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu16_flags dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .byteMode(byteMode),
    .opA(opA), .opB(opB), .setTrap(setTrap), .clrTrap(clrTrap), .setIntEn(setIntEn),
    .clrIntEn(clrIntEn), .setDir(setDir), .clrDir(clrDir),
    .result(result), .flagWord(flagWord), .intEnable(intEnable)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        byt;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] res;
    logic [15:0] flg;
  } vec_t;

  // rows are ordered: ADC/SBB rows depend on CF left by the row before
  localparam vec_t VEC [12] = '{
    '{3'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 16'h0057},
    '{3'd1, 1'b0, 16'h7FFF, 16'h0000, 16'h8000, 16'h0896},
    '{3'd2, 1'b0, 16'h0000, 16'h0001, 16'hFFFF, 16'h0097},
    '{3'd3, 1'b0, 16'h8000, 16'h0000, 16'h7FFF, 16'h0816},
    '{3'd4, 1'b0, 16'hF0F0, 16'h3C3C, 16'h3030, 16'h0006},
    '{3'd5, 1'b0, 16'h8001, 16'h0000, 16'h8001, 16'h0082},
    '{3'd6, 1'b1, 16'h12AA, 16'h3455, 16'h00FF, 16'h0086},
    '{3'd0, 1'b1, 16'h007F, 16'h0001, 16'h0080, 16'h0892},
    '{3'd0, 1'b1, 16'hAAFF, 16'h5501, 16'h0000, 16'h0057},
    '{3'd3, 1'b1, 16'h0010, 16'h0000, 16'h000F, 16'h0016},
    '{3'd2, 1'b1, 16'h0080, 16'h0001, 16'h007F, 16'h0812},
    '{3'd1, 1'b1, 16'h0001, 16'h0001, 16'h0002, 16'h0002}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic applyOp(input logic valid, input logic [2:0] op, input logic byt,
                         input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    opValid = valid; opCode = op; byteMode = byt; opA = a; opB = b;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic strobe(input logic sT, input logic cT, input logic sI,
                        input logic cI, input logic sD, input logic cD);
    @(negedge clk);
    setTrap = sT; clrTrap = cT; setIntEn = sI; clrIntEn = cI; setDir = sD; clrDir = cD;
    @(negedge clk);
    setTrap = 0; clrTrap = 0; setIntEn = 0; clrIntEn = 0; setDir = 0; clrDir = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 result in reset", result, 16'h0000);
    check("R1 flags in reset", flagWord, 16'h0002);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 flags after release", flagWord, 16'h0002);

    // table: R2 R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < 12; i++) begin
      applyOp(1'b1, VEC[i].op, VEC[i].byt, VEC[i].a, VEC[i].b);
      check($sformatf("R2/R3/R4 result row %0d", i), result, VEC[i].res);
      check($sformatf("R5 R6 R7 R8 R10 flags row %0d", i), flagWord, VEC[i].flg);
    end

    // R11: reserved opcode and idle cycles change nothing
    applyOp(1'b1, 3'd7, 1'b0, 16'hFFFF, 16'h0001);
    check("R11 result after opcode 7", result, 16'h0002);
    check("R11 flags after opcode 7", flagWord, 16'h0002);
    applyOp(1'b0, 3'd0, 1'b0, 16'hFFFF, 16'h0001);
    check("R11 result with opValid low", result, 16'h0002);
    check("R11 flags with opValid low", flagWord, 16'h0002);

    // R9: control flag strobes, R10 layout of bits 8..10
    strobe(1, 0, 1, 0, 1, 0);
    check("R9 R10 control flags set", flagWord, 16'h0702);
    check("R9 intEnable pin", {15'b0, intEnable}, 16'h0001);
    applyOp(1'b1, 3'd0, 1'b0, 16'hFFFF, 16'h0001);
    check("R9 arithmetic keeps control flags", flagWord, 16'h0757);
    strobe(0, 0, 1, 1, 0, 0);
    check("R9 clear wins over set", flagWord, 16'h0557);
    check("R9 intEnable cleared", {15'b0, intEnable}, 16'h0000);
    strobe(0, 1, 0, 0, 0, 1);
    check("R9 trap and direction cleared", flagWord, 16'h0057);

    // R1: reset again mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 result after second reset", result, 16'h0000);
    check("R1 flags after second reset", flagWord, 16'h0002);
    rstN = 1'b1;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule